// File: doc/BRIEF.md
# Status Register Flag Controller

This block keeps an eight-bit processor status word and applies the single-bit flag commands that a decoder sends it. A flag can be written by its bit number or through a command that names that flag. Every clock the flag-update outputs of the arithmetic unit are merged into the same word. The interrupt enable flag is brought out on its own pin, because it acts as the global interrupt enable.

The block also resolves a conditional relative branch that tests the interrupt enable flag. It retires every accepted command by presenting the following program counter. A branch that is not taken retires after one cycle. A taken branch needs a second cycle. During that extra cycle the command port drops `cmd_ready`, so the decoder must hold its next command. A command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the fields on the command port are ignored. The program counter result is a plain qualified output with no back-pressure: `pc_vld_o` is high for one cycle for each retired command.

Top module: `sreg_flag_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all eight flags read 0, `pc_vld_o` is 0 and `cmd_ready` is 1.
- R2: Flag layout in `sreg_o`: bit 7 is I, bit 6 is T, bit 5 is H, bit 4 is S, bit 3 is V, bit 2 is N, bit 1 is Z and bit 0 is C. An accepted op 5'd1 (indexed set) makes bit `cmd_idx` read 1 in the next cycle. Other bits change only through the arithmetic-unit update.
- R3: An accepted op 5'd2 (indexed clear) makes bit `cmd_idx` read 0 in the next cycle. Other bits change only through the arithmetic-unit update.
- R4: An accepted named op has the form {1'b1, v, f[2:0]}. It writes the value v to one flag, chosen by f: 0 is C (bit 0), 1 is N (bit 2), 2 is Z (bit 1), 3 is I (bit 7), 4 is S (bit 4), 5 is V (bit 3), 6 is T (bit 6) and 7 is H (bit 5). `irq_en_o` always equals flag I.
- R5: On every rising edge, each bit whose `alu_we` bit is 1 takes the matching `alu_flags` bit, and it is visible in the next cycle.
- R6: If an explicit flag command and an arithmetic-unit update target the same bit in one cycle, the command's value wins for that bit. The other bits still take their arithmetic-unit update.
- R7: Op 5'd3 branches when I is 1. Op 5'd4 branches when I is 0. I is read as the flag value in the cycle the command is accepted, before that cycle's updates.
- R8: A branch that is not taken retires in the next cycle: `pc_vld_o`=1, `pc_next_o`=`pc_in`+1 and `long_o`=0. `cmd_ready` stays 1.
- R9: A taken branch holds `cmd_ready`=0 and `pc_vld_o`=0 in the next cycle. In the cycle after that it gives `pc_vld_o`=1, `long_o`=1 and `pc_next_o` = `pc_in` + sign-extended `cmd_off` + 1, modulo 2^PC_W.
- R10: Op 5'd0, ops 5'd5 to 5'd15 and ops 5'd1 and 5'd2 retire in the next cycle with `pc_next_o`=`pc_in`+1 and `long_o`=0. Ops 5'd0 and 5'd5 to 5'd15 leave every flag unchanged. When no command is accepted, `pc_vld_o` is 0 in the next cycle.
- R11: A command offered while `cmd_ready` is 0 is not accepted: it changes no flag and retires nothing. `cmd_ready` never stays low for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command port can accept |
| cmd_op | input | 5 | Command code |
| cmd_idx | input | 3 | Bit number for indexed set/clear |
| cmd_off | input | 7 | Signed branch word offset |
| pc_in | input | 16 | Program counter of the command |
| alu_we | input | 8 | Per-flag update enables from the arithmetic unit |
| alu_flags | input | 8 | Flag values from the arithmetic unit |
| sreg_o | output | 8 | Status word |
| irq_en_o | output | 1 | Global interrupt enable (flag I) |
| pc_vld_o | output | 1 | A command retires this cycle |
| pc_next_o | output | 16 | Next program counter |
| long_o | output | 1 | The retiring command took two cycles |

## Verification
Two functions can fall in the same cycle. An explicit flag command can coincide with the arithmetic-unit update, and a taken branch's stall cycle can coincide with a new command offer. Directed cases drive a set or clear together with an update enable on the same bit and on other bits. The bench expects the command's value only on the target bit and the arithmetic-unit values elsewhere. Random stimulus keeps update enables and commands overlapping, and it offers commands during stalls; a reference model judges each cycle, checking that the stalled offer is dropped and that the branch retires exactly one cycle later.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int NFLAG = 8;
  localparam int OP_W  = 5;
  localparam int IDX_W = $clog2(NFLAG);

  localparam logic [OP_W-1:0] OP_NOP     = 5'd0;
  localparam logic [OP_W-1:0] OP_SET_IDX = 5'd1;
  localparam logic [OP_W-1:0] OP_CLR_IDX = 5'd2;
  localparam logic [OP_W-1:0] OP_BR_ON   = 5'd3;
  localparam logic [OP_W-1:0] OP_BR_OFF  = 5'd4;

  localparam int POS_I = 7;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] pos;
    logic             val;
    logic             is_br;
    logic             br_on_set;
  } dec_t;

  // named flag code -> bit position in the status word
  function automatic logic [IDX_W-1:0] named_pos(input logic [2:0] code);
    case (code)
      3'd0:    named_pos = 3'd0; // C
      3'd1:    named_pos = 3'd2; // N
      3'd2:    named_pos = 3'd1; // Z
      3'd3:    named_pos = 3'd7; // I
      3'd4:    named_pos = 3'd4; // S
      3'd5:    named_pos = 3'd3; // V
      3'd6:    named_pos = 3'd6; // T
      default: named_pos = 3'd5; // H
    endcase
  endfunction
endpackage

// File: rtl/sfc_decode.sv
module sfc_decode
  import sfc_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic [IDX_W-1:0] idx,
  output dec_t             dec
);
  always_comb begin
    dec = '0;
    if (op[OP_W-1]) begin
      dec.hit = 1'b1;
      dec.val = op[3];
      dec.pos = named_pos(op[2:0]);
    end else begin
      case (op)
        OP_SET_IDX: begin dec.hit = 1'b1; dec.val = 1'b1; dec.pos = idx; end
        OP_CLR_IDX: begin dec.hit = 1'b1; dec.val = 1'b0; dec.pos = idx; end
        OP_BR_ON:   begin dec.is_br = 1'b1; dec.br_on_set = 1'b1; end
        OP_BR_OFF:  begin dec.is_br = 1'b1; dec.br_on_set = 1'b0; end
        default:    dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/sfc_flagreg.sv
module sfc_flagreg #(
  parameter int NF = 8,
  localparam int IW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_hit,
  input  logic [IW-1:0] cmd_pos,
  input  logic          cmd_val,
  input  logic [NF-1:0] alu_we,
  input  logic [NF-1:0] alu_val,
  output logic [NF-1:0] q
);
  logic [NF-1:0] nxt;

  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_comb begin
      if (cmd_hit && (cmd_pos == IW'(i)))
        nxt[i] = cmd_val;          // explicit command wins for its bit
      else if (alu_we[i])
        nxt[i] = alu_val[i];
      else
        nxt[i] = q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/sfc_branch.sv
module sfc_branch #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             is_br,
  input  logic             br_on_set,
  input  logic             ie_flag,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [OFF_W-1:0] off,
  output logic             ready,
  output logic             pc_vld,
  output logic [PC_W-1:0]  pc_next,
  output logic             long_lat
);
  localparam int EXT_W = PC_W - OFF_W;

  logic            busy;
  logic            taken;
  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] tgt_pc;

  assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
  assign seq_pc  = pc_in + PC_W'(1);
  assign tgt_pc  = seq_pc + off_ext;
  assign taken   = is_br && (ie_flag == br_on_set);
  assign ready   = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pc_vld   <= 1'b0;
      pc_next  <= '0;
      long_lat <= 1'b0;
    end else if (busy) begin
      busy     <= 1'b0;
      pc_vld   <= 1'b1;            // target was loaded at acceptance
      long_lat <= 1'b1;
    end else if (acc) begin
      if (taken) begin
        busy     <= 1'b1;
        pc_vld   <= 1'b0;
        pc_next  <= tgt_pc;
        long_lat <= 1'b1;
      end else begin
        pc_vld   <= 1'b1;
        pc_next  <= seq_pc;
        long_lat <= 1'b0;
      end
    end else begin
      pc_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/sreg_flag_ctrl.sv
module sreg_flag_ctrl
  import sfc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [4:0]       cmd_op,
  input  logic [2:0]       cmd_idx,
  input  logic [OFF_W-1:0] cmd_off,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [7:0]       alu_we,
  input  logic [7:0]       alu_flags,
  output logic [7:0]       sreg_o,
  output logic             irq_en_o,
  output logic             pc_vld_o,
  output logic [PC_W-1:0]  pc_next_o,
  output logic             long_o
);
  logic acc;
  dec_t dec;

  assign acc = cmd_valid && cmd_ready;

  sfc_decode u_dec (
    .op  (cmd_op),
    .idx (cmd_idx),
    .dec (dec)
  );

  sfc_flagreg #(.NF(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_hit (acc && dec.hit),
    .cmd_pos (dec.pos),
    .cmd_val (dec.val),
    .alu_we  (alu_we),
    .alu_val (alu_flags),
    .q       (sreg_o)
  );

  sfc_branch #(.PC_W(PC_W), .OFF_W(OFF_W)) u_br (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .is_br     (dec.is_br),
    .br_on_set (dec.br_on_set),
    .ie_flag   (sreg_o[POS_I]),
    .pc_in     (pc_in),
    .off       (cmd_off),
    .ready     (cmd_ready),
    .pc_vld    (pc_vld_o),
    .pc_next   (pc_next_o),
    .long_lat  (long_o)
  );

  assign irq_en_o = sreg_o[POS_I];
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [4:0]      cmd_op,
  input logic [2:0]      cmd_idx,
  input logic [PC_W-1:0] pc_in,
  input logic [7:0]      alu_we,
  input logic [7:0]      alu_flags,
  input logic [7:0]      sreg_o,
  input logic            pc_vld_o,
  input logic [PC_W-1:0] pc_next_o,
  input logic            long_o
);
  logic acc, explicit_cmd, br_taken, br_not;
  assign acc          = cmd_valid && cmd_ready;
  assign explicit_cmd = cmd_op[4] || (cmd_op == 5'd1) || (cmd_op == 5'd2);
  assign br_taken     = (cmd_op == 5'd3 && sreg_o[7]) || (cmd_op == 5'd4 && !sreg_o[7]);
  assign br_not       = (cmd_op == 5'd3 && !sreg_o[7]) || (cmd_op == 5'd4 && sreg_o[7]);

  assert_idx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 5'd1) |=> sreg_o[$past(cmd_idx)]);

  assert_idx_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 5'd2) |=> !sreg_o[$past(cmd_idx)]);

  assert_named_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 5'b11011) |=> sreg_o[7]);

  assert_alu_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc && explicit_cmd) && alu_we == 8'hFF) |=> (sreg_o == $past(alu_flags)));

  assert_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && br_not) |=> (pc_vld_o && !long_o && pc_next_o == $past(pc_in) + PC_W'(1)));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && br_taken) |=> (!cmd_ready && !pc_vld_o));

  assert_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && br_taken) |=> ##1 (pc_vld_o && long_o));

  assert_ready_back_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> cmd_ready);
endmodule

bind sreg_flag_ctrl sfc_checker #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_idx   (cmd_idx),
  .pc_in     (pc_in),
  .alu_we    (alu_we),
  .alu_flags (alu_flags),
  .sreg_o    (sreg_o),
  .pc_vld_o  (pc_vld_o),
  .pc_next_o (pc_next_o),
  .long_o    (long_o)
);

// File: tb/sim_sreg_flag_ctrl.sv
module sim_sreg_flag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [4:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic [6:0]  cmd_off = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  alu_we = '0;
  logic [7:0]  alu_flags = '0;
  logic [7:0]  sreg_o;
  logic        irq_en_o;
  logic        pc_vld_o;
  logic [15:0] pc_next_o;
  logic        long_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0]  m_sreg = '0;
  logic        m_busy = 1'b0;
  logic [15:0] m_pend = '0;

  always #10 clk = ~clk;

  sreg_flag_ctrl u0 (.*);

  function automatic logic [2:0] nm_pos(input logic [2:0] f);
    logic [2:0] t [8] = '{3'd0, 3'd2, 3'd1, 3'd7, 3'd4, 3'd3, 3'd6, 3'd5};
    return t[f];
  endfunction

  function automatic logic [15:0] br_target(input logic [15:0] pc, input logic [6:0] k);
    return pc + {{9{k[6]}}, k} + 16'd1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  // one cycle: drive at negedge, model, check at next negedge
  task automatic step(input logic v, input logic [4:0] op, input logic [2:0] idx,
                      input logic [6:0] off, input logic [15:0] pc,
                      input logic [7:0] we, input logic [7:0] fl);
    logic acc, hit, val, isbr, tk;
    logic [2:0] pos;
    logic [7:0] ns;
    logic       e_vld, e_long;
    logic [15:0] e_pc;
    string stag, ptag;
    cmd_valid = v; cmd_op = op; cmd_idx = idx; cmd_off = off;
    pc_in = pc; alu_we = we; alu_flags = fl;
    chk("R11", "cmd_ready", cmd_ready, !m_busy);
    acc = v && !m_busy;
    hit = 1'b0; val = 1'b0; pos = 3'd0;
    if (op[4])          begin hit = 1'b1; val = op[3]; pos = nm_pos(op[2:0]); end
    else if (op == 5'd1) begin hit = 1'b1; val = 1'b1; pos = idx; end
    else if (op == 5'd2) begin hit = 1'b1; val = 1'b0; pos = idx; end
    isbr = (op == 5'd3) || (op == 5'd4);
    tk   = (op == 5'd3 && m_sreg[7]) || (op == 5'd4 && !m_sreg[7]);
    ns = (m_sreg & ~we) | (fl & we);
    stag = "R5";
    if (v && m_busy) stag = "R11";
    if (acc && hit) begin
      ns[pos] = val;
      stag = we[pos] ? "R6" : (op[4] ? "R4" : (op == 5'd1 ? "R2" : "R3"));
    end else if (acc && !isbr) stag = "R10";
    e_vld = 1'b0; e_long = 1'b0; e_pc = '0; ptag = "R10";
    if (m_busy) begin
      e_vld = 1'b1; e_long = 1'b1; e_pc = m_pend; m_busy = 1'b0; ptag = "R9";
    end else if (acc) begin
      if (isbr && tk) begin
        m_busy = 1'b1; m_pend = br_target(pc, off); ptag = "R7";
      end else begin
        e_vld = 1'b1; e_pc = pc + 16'd1; ptag = isbr ? "R8" : "R10";
      end
    end else if (v) ptag = "R11";
    m_sreg = ns;
    @(negedge clk);
    chk(stag, "sreg_o", sreg_o, m_sreg);
    chk("R4", "irq_en_o", irq_en_o, m_sreg[7]);
    chk(ptag, "pc_vld_o", pc_vld_o, e_vld);
    if (e_vld) begin
      chk(ptag, "pc_next_o", pc_next_o, e_pc);
      chk(ptag, "long_o", long_o, e_long);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "sreg in reset", sreg_o, 0);
    chk("R1", "pc_vld in reset", pc_vld_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sreg after reset", sreg_o, 0);
    chk("R1", "ready after reset", cmd_ready, 1);

    // R2 / R3 indexed set and clear
    step(1, 5'd1, 3'd3, 0, 16'h0100, 0, 0);
    step(1, 5'd1, 3'd7, 0, 16'h0101, 0, 0);
    step(1, 5'd2, 3'd3, 0, 16'h0102, 0, 0);
    // R4 every named set then clear
    for (int f = 0; f < 8; f++) step(1, {2'b11, 3'(f)}, 0, 0, 16'h0200, 0, 0);
    for (int f = 0; f < 8; f++) step(1, {2'b10, 3'(f)}, 0, 0, 16'h0210, 0, 0);
    // R5 arithmetic update only
    step(0, 0, 0, 0, 0, 8'h0F, 8'h05);
    // R6 collision on the same bit plus others
    step(1, 5'd2, 3'd0, 0, 16'h0300, 8'hFF, 8'hFF);
    step(1, 5'b11000, 0, 0, 16'h0301, 8'h81, 8'h00);
    // R10 ignored ops
    step(1, 5'd9, 3'd5, 0, 16'h0400, 0, 0);
    step(1, 5'd0, 3'd5, 0, 16'h0401, 0, 0);
    // R7/R8/R9 branch: I currently 0
    step(1, 5'd3, 0, 7'h3F, 16'h0500, 0, 0);          // not taken
    step(1, 5'd4, 0, 7'h3F, 16'h0600, 0, 0);          // taken +63
    step(1, 5'd1, 3'd2, 0, 16'h0700, 0, 0);           // offered in stall: dropped
    step(1, 5'b11011, 0, 0, 16'h0800, 0, 0);          // set I
    step(1, 5'd3, 0, 7'h40, 16'h0010, 0, 0);          // taken -64, wraps
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 5'd3, 0, 7'h00, 16'hFFFF, 8'h80, 8'h00);  // taken, I cleared same cycle
    step(1, 5'd4, 0, 0, 16'h0900, 0, 0);              // stall, offer dropped
    step(1, 5'd4, 0, 7'h01, 16'hFFFF, 0, 0);          // I now 0: taken, wraps
    step(0, 0, 0, 0, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [4:0] op;
      int sel = $urandom % 8;
      case (sel)
        0, 1:    op = 5'(1 + ($urandom % 2));
        2, 3:    op = 5'(3 + ($urandom % 2));
        4, 5, 6: op = {1'b1, 4'($urandom)};
        default: op = 5'($urandom % 16);
      endcase
      step(($urandom % 4) != 0, op, 3'($urandom), 7'($urandom), 16'($urandom),
           (($urandom % 2) != 0) ? 8'($urandom) : 8'h00, 8'($urandom));
    end
    done = 1'b1;
    summary();
  end
endmodule